// File: doc/BRIEF.md
# Looping Accumulator Processor

This block is a compact multi-cycle processor built around 16-bit words. It has a program counter, a memory address register, a memory data register, an instruction register, and three working registers. The accumulator collects sums. The step register supplies the addend. The count register drives the loop. All of them exchange data over one internal bus, which is a multiplexer with exactly one source selected per state. A state machine steps through fetch, decode and execute. Each step is a single clock cycle and carries a fixed set of micro-operations.

A 32-word memory holds both instructions and data. A synchronous reset refills it with a small summing program. The program works as follows:
- It loads a start value into the accumulator.
- It loads a loop count into the count register.
- It loads an immediate into the step register.
- It then repeats add, step-increment and count-decrement, using a conditional jump, until the count reaches zero.
- Finally it stores the accumulator to a result word and halts.

With the default parameters the result is 1+2+...+10 = 55. Debug outputs show the accumulator, program counter, step and count registers and the 4-bit state code. A peek port reads any memory word combinationally. Opcodes 8 to 15 are not defined and drive the machine into its halt state.

Top module: `sumloop_cpu`

## Requirements
- R1: While `rst` is sampled high at a clock edge, the PC, accumulator, step and count registers go to 0, the state code goes to 0 and `halted` is low. The memory is refilled with the program and its data, so a second run after a halt repeats the first run exactly.
- R2: An instruction word carries its opcode in bits 15:12 and its operand field in bits 11:0. Fetch uses state codes 0, 1 and 2 and then decodes in state 3. In state 0 the PC is copied to the memory address register and the PC increments, so one edge after reset is released the PC reads 1 and the state code reads 1.
- R3: Opcode 0 loads the accumulator from the memory word at the operand address. It completes 6 cycles after its fetch begins.
- R4: Opcode 1 loads the count register from the memory word at the operand address. Opcode 2 loads the step register with the operand field, zero-extended. Opcode 4 adds 1 to the step register. Opcode 5 subtracts 1 from the count register.
- R5: Opcode 3 replaces the accumulator with the accumulator plus the step register. Each of opcodes 2, 3, 4 and 5 takes 5 cycles.
- R6: Opcode 6 tests the count register as it stands at decode. If the count is non-zero, the PC is loaded with the zero-extended operand field, taking 5 cycles in total. If the count is zero, execution goes on with the next word, taking 4 cycles.
- R7: Opcode 7 writes the accumulator to the memory word at the operand address. The machine then enters the halt state (code 13) and raises `halted`. A halted machine changes none of its registers or memory until reset. Opcodes 8 to 15 also enter the halt state.
- R8: After a run with start value A, immediate B and count N, where N ≥ 1:
  - the accumulator and result word 19 both hold A + N·B + N(N−1)/2;
  - the step register holds B+N;
  - the count register holds 0;
  - the PC holds 8;
  - `halted` first reads high 22+20·N cycles after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high, reloads memory |
| halted | output | 1 | High while the machine is in the halt state |
| dbg_ac | output | 16 | Accumulator value |
| dbg_pc | output | 16 | Program counter value |
| dbg_bx | output | 16 | Step register value |
| dbg_cx | output | 16 | Count register value |
| dbg_state | output | 4 | Current controller state code |
| peek_addr | input | 5 | Memory word to observe |
| peek_data | output | 16 | Contents of the memory word at `peek_addr` |

## Verification
The bench builds two copies of the block side by side. The first uses the default start value 1, immediate 2 and count 9. It runs the full loop, so the taken jump is exercised eight times and the final fall-through once. The second uses start value 100, immediate 7 and count 1. Its very first jump is not taken, which reaches the fall-through path and the shortest possible run (42 cycles). Both copies are traced at the same cycle numbers, so the taken and not-taken jump outcomes can be compared directly.

// File: rtl/sumloop_pkg.sv
package sumloop_pkg;

  localparam int OPC_W = 4;

  typedef enum logic [OPC_W-1:0] {
    OPC_LDA = 4'd0,
    OPC_LDC = 4'd1,
    OPC_LDB = 4'd2,
    OPC_ADD = 4'd3,
    OPC_INB = 4'd4,
    OPC_DCC = 4'd5,
    OPC_JNZ = 4'd6,
    OPC_STO = 4'd7
  } opc_e;

  typedef enum logic [3:0] {
    ST_FADDR = 4'd0,
    ST_FMEM  = 4'd1,
    ST_FIR   = 4'd2,
    ST_DECO  = 4'd3,
    ST_OPRD  = 4'd4,
    ST_LDA   = 4'd5,
    ST_LDC   = 4'd6,
    ST_ADD   = 4'd7,
    ST_LDB   = 4'd8,
    ST_INB   = 4'd9,
    ST_DCC   = 4'd10,
    ST_STM   = 4'd11,
    ST_STW   = 4'd12,
    ST_HALT  = 4'd13,
    ST_JMP   = 4'd14
  } state_e;

  typedef enum logic [2:0] {
    BUS_NONE,
    BUS_PC,
    BUS_MDR,
    BUS_FIELD,
    BUS_ACC
  } bus_src_e;

  typedef enum logic { ACC_FROM_BUS, ACC_FROM_SUM } acc_sel_e;
  typedef enum logic { MDR_FROM_MEM, MDR_FROM_BUS } mdr_sel_e;

  typedef struct packed {
    bus_src_e bus_src;
    logic     mar_load;
    logic     pc_inc;
    logic     pc_jump;
    logic     mdr_load;
    mdr_sel_e mdr_sel;
    logic     ir_load;
    logic     acc_load;
    acc_sel_e acc_sel;
    logic     bx_load;
    logic     bx_inc;
    logic     cx_load;
    logic     cx_dec;
    logic     mem_we;
  } ctl_t;

endpackage

// File: rtl/sumloop_mem.sv
module sumloop_mem
  import sumloop_pkg::*;
#(
  parameter int WORD_W      = 16,
  parameter int DEPTH       = 32,
  parameter int FIRST_VAL   = 1,
  parameter int LOOP_COUNT  = 9,
  parameter int STEP_START  = 2,
  parameter int RESULT_ADDR = 19,
  localparam int ADDR_W     = $clog2(DEPTH),
  localparam int FIELD_W    = WORD_W - OPC_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rdata,
  input  logic [ADDR_W-1:0] peek_addr,
  output logic [WORD_W-1:0] peek_data
);

  localparam int START_ADDR = 8;
  localparam int COUNT_ADDR = 9;
  localparam int LOOP_ADDR  = 3;

  logic [WORD_W-1:0] words [DEPTH];

  function automatic logic [WORD_W-1:0] insn(opc_e op, int field);
    return {op, FIELD_W'(field)};
  endfunction

  function automatic logic [WORD_W-1:0] boot_word(int idx);
    case (idx)
      0:          return insn(OPC_LDA, START_ADDR);
      1:          return insn(OPC_LDC, COUNT_ADDR);
      2:          return insn(OPC_LDB, STEP_START);
      3:          return insn(OPC_ADD, 0);
      4:          return insn(OPC_INB, 0);
      5:          return insn(OPC_DCC, 0);
      6:          return insn(OPC_JNZ, LOOP_ADDR);
      7:          return insn(OPC_STO, RESULT_ADDR);
      START_ADDR: return WORD_W'(FIRST_VAL);
      COUNT_ADDR: return WORD_W'(LOOP_COUNT);
      default:    return '0;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) words[i] <= boot_word(i);
    end else if (we) begin
      words[addr] <= wdata;
    end
  end

  assign rdata     = words[addr];
  assign peek_data = words[peek_addr];

  // R7: a store lands in the addressed word
  a_r7_store_lands: assert property (@(posedge clk) disable iff (rst)
    we |=> words[$past(addr)] == $past(wdata));

endmodule

// File: rtl/sumloop_ctrl.sv
module sumloop_ctrl
  import sumloop_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [OPC_W-1:0] opcode,
  input  logic             cx_zero,
  output ctl_t             ctl,
  output state_e           state
);

  state_e nxt;

  always_ff @(posedge clk) begin
    if (rst) state <= ST_FADDR;
    else     state <= nxt;
  end

  always_comb begin
    nxt = state;
    case (state)
      ST_FADDR: nxt = ST_FMEM;
      ST_FMEM:  nxt = ST_FIR;
      ST_FIR:   nxt = ST_DECO;
      ST_DECO: begin
        case (opcode)
          OPC_LDA, OPC_LDC: nxt = ST_OPRD;
          OPC_LDB:          nxt = ST_LDB;
          OPC_ADD:          nxt = ST_ADD;
          OPC_INB:          nxt = ST_INB;
          OPC_DCC:          nxt = ST_DCC;
          OPC_JNZ:          nxt = cx_zero ? ST_FADDR : ST_JMP;
          OPC_STO:          nxt = ST_STM;
          default:          nxt = ST_HALT;
        endcase
      end
      ST_OPRD:  nxt = (opcode == OPC_LDA) ? ST_LDA : ST_LDC;
      ST_STM:   nxt = ST_STW;
      ST_STW:   nxt = ST_HALT;
      ST_HALT:  nxt = ST_HALT;
      default:  nxt = ST_FADDR;
    endcase
  end

  always_comb begin
    ctl = '0;
    case (state)
      ST_FADDR: begin ctl.bus_src = BUS_PC;    ctl.mar_load = 1'b1; ctl.pc_inc = 1'b1; end
      ST_FMEM:  begin ctl.mdr_load = 1'b1;     ctl.mdr_sel = MDR_FROM_MEM; end
      ST_FIR:   begin ctl.bus_src = BUS_MDR;   ctl.ir_load = 1'b1; end
      ST_DECO:  begin ctl.bus_src = BUS_FIELD; ctl.mar_load = 1'b1; end
      ST_OPRD:  begin ctl.mdr_load = 1'b1;     ctl.mdr_sel = MDR_FROM_MEM; end
      ST_LDA:   begin ctl.bus_src = BUS_MDR;   ctl.acc_load = 1'b1; ctl.acc_sel = ACC_FROM_BUS; end
      ST_LDC:   begin ctl.bus_src = BUS_MDR;   ctl.cx_load = 1'b1; end
      ST_ADD:   begin ctl.acc_load = 1'b1;     ctl.acc_sel = ACC_FROM_SUM; end
      ST_LDB:   begin ctl.bus_src = BUS_FIELD; ctl.bx_load = 1'b1; end
      ST_INB:   ctl.bx_inc = 1'b1;
      ST_DCC:   ctl.cx_dec = 1'b1;
      ST_STM:   begin ctl.bus_src = BUS_ACC;   ctl.mdr_load = 1'b1; ctl.mdr_sel = MDR_FROM_BUS; end
      ST_STW:   ctl.mem_we = 1'b1;
      ST_JMP:   begin ctl.bus_src = BUS_FIELD; ctl.pc_jump = 1'b1; end
      default:  ctl = '0;
    endcase
  end

  // R7: undefined opcodes park the machine
  a_r7_bad_op_halts: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DECO && opcode[OPC_W-1]) |=> state == ST_HALT);

  // R6: a zero count never takes the jump
  a_r6_zero_falls_through: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DECO && opcode == OPC_JNZ && cx_zero) |=> state == ST_FADDR);

endmodule

// File: rtl/sumloop_datapath.sv
module sumloop_datapath
  import sumloop_pkg::*;
#(
  parameter int WORD_W   = 16,
  localparam int FIELD_W = WORD_W - OPC_W
) (
  input  logic             clk,
  input  logic             rst,
  input  ctl_t             ctl,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic [WORD_W-1:0] mar,
  output logic [WORD_W-1:0] mdr,
  output logic [OPC_W-1:0] opcode,
  output logic             cx_zero,
  output logic [WORD_W-1:0] pc,
  output logic [WORD_W-1:0] acc,
  output logic [WORD_W-1:0] bx,
  output logic [WORD_W-1:0] cx
);

  logic [WORD_W-1:0] ir;
  logic [WORD_W-1:0] bus;
  logic [WORD_W-1:0] field_ext;

  assign field_ext = {{OPC_W{1'b0}}, ir[FIELD_W-1:0]};
  assign opcode    = ir[WORD_W-1 -: OPC_W];
  assign cx_zero   = (cx == '0);

  always_comb begin
    case (ctl.bus_src)
      BUS_PC:    bus = pc;
      BUS_MDR:   bus = mdr;
      BUS_FIELD: bus = field_ext;
      BUS_ACC:   bus = acc;
      default:   bus = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc  <= '0; mar <= '0; mdr <= '0; ir <= '0;
      acc <= '0; bx  <= '0; cx  <= '0;
    end else begin
      if (ctl.mar_load) mar <= bus;
      if (ctl.pc_jump)     pc <= bus;
      else if (ctl.pc_inc) pc <= pc + 1'b1;
      if (ctl.mdr_load) mdr <= (ctl.mdr_sel == MDR_FROM_MEM) ? mem_rdata : bus;
      if (ctl.ir_load)  ir  <= bus;
      if (ctl.acc_load) acc <= (ctl.acc_sel == ACC_FROM_BUS) ? bus : acc + bx;
      if (ctl.bx_load)     bx <= bus;
      else if (ctl.bx_inc) bx <= bx + 1'b1;
      if (ctl.cx_load)     cx <= bus;
      else if (ctl.cx_dec) cx <= cx - 1'b1;
    end
  end

  // R2: fetch step advances the PC by one
  a_r2_pc_step: assert property (@(posedge clk) disable iff (rst)
    ctl.pc_inc && !ctl.pc_jump |=> pc == $past(pc) + 1'b1);

  // R5: add uses the pre-edge accumulator and step values
  a_r5_add_sum: assert property (@(posedge clk) disable iff (rst)
    ctl.acc_load && ctl.acc_sel == ACC_FROM_SUM |=> acc == $past(acc) + $past(bx));

  // R4: decrement lowers the count by one
  a_r4_count_down: assert property (@(posedge clk) disable iff (rst)
    ctl.cx_dec && !ctl.cx_load |=> cx == $past(cx) - 1'b1);

  // R6: a taken jump lands on the zero-extended field
  a_r6_jump_target: assert property (@(posedge clk) disable iff (rst)
    ctl.pc_jump |=> pc == {{OPC_W{1'b0}}, $past(ir[FIELD_W-1:0])});

endmodule

// File: rtl/sumloop_cpu.sv
module sumloop_cpu
  import sumloop_pkg::*;
#(
  parameter int WORD_W      = 16,
  parameter int MEM_DEPTH   = 32,
  parameter int FIRST_VAL   = 1,
  parameter int LOOP_COUNT  = 9,
  parameter int STEP_START  = 2,
  parameter int RESULT_ADDR = 19,
  localparam int ADDR_W     = $clog2(MEM_DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  output logic              halted,
  output logic [WORD_W-1:0] dbg_ac,
  output logic [WORD_W-1:0] dbg_pc,
  output logic [WORD_W-1:0] dbg_bx,
  output logic [WORD_W-1:0] dbg_cx,
  output logic [3:0]        dbg_state,
  input  logic [ADDR_W-1:0] peek_addr,
  output logic [WORD_W-1:0] peek_data
);

  ctl_t              ctl;
  state_e            state;
  logic [OPC_W-1:0]  opcode;
  logic              cx_zero;
  logic [WORD_W-1:0] mar, mdr, mem_rdata;

  sumloop_ctrl u_ctrl (
    .clk(clk), .rst(rst), .opcode(opcode), .cx_zero(cx_zero),
    .ctl(ctl), .state(state)
  );

  sumloop_datapath #(.WORD_W(WORD_W)) u_dp (
    .clk(clk), .rst(rst), .ctl(ctl), .mem_rdata(mem_rdata),
    .mar(mar), .mdr(mdr), .opcode(opcode), .cx_zero(cx_zero),
    .pc(dbg_pc), .acc(dbg_ac), .bx(dbg_bx), .cx(dbg_cx)
  );

  sumloop_mem #(
    .WORD_W(WORD_W), .DEPTH(MEM_DEPTH), .FIRST_VAL(FIRST_VAL),
    .LOOP_COUNT(LOOP_COUNT), .STEP_START(STEP_START), .RESULT_ADDR(RESULT_ADDR)
  ) u_mem (
    .clk(clk), .rst(rst), .addr(mar[ADDR_W-1:0]), .we(ctl.mem_we),
    .wdata(mdr), .rdata(mem_rdata), .peek_addr(peek_addr), .peek_data(peek_data)
  );

  assign halted    = (state == ST_HALT);
  assign dbg_state = state;

  // R7: nothing moves once halted
  a_r7_halt_holds: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted && $stable(dbg_ac) && $stable(dbg_pc) && $stable(dbg_bx)
               && $stable(dbg_cx) && !ctl.mem_we);

endmodule

// File: tb/sumloop_cpu_tb_top.sv
`timescale 1ns/1ps
module sumloop_cpu_tb_top;

  localparam int A0 = 1,   B0 = 2, N0 = 9;
  localparam int A1 = 100, B1 = 7, N1 = 1;
  localparam int RES = 19;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic        halt_w [2];
  logic [15:0] ac_w [2], pc_w [2], bx_w [2], cx_w [2], pk_w [2];
  logic [3:0]  st_w [2];
  logic [4:0]  peek = 5'(RES);

  sumloop_cpu dut_i (
    .clk(clk), .rst(rst), .halted(halt_w[0]), .dbg_ac(ac_w[0]), .dbg_pc(pc_w[0]),
    .dbg_bx(bx_w[0]), .dbg_cx(cx_w[0]), .dbg_state(st_w[0]),
    .peek_addr(peek), .peek_data(pk_w[0])
  );

  sumloop_cpu #(.FIRST_VAL(A1), .LOOP_COUNT(N1), .STEP_START(B1)) dut_short (
    .clk(clk), .rst(rst), .halted(halt_w[1]), .dbg_ac(ac_w[1]), .dbg_pc(pc_w[1]),
    .dbg_bx(bx_w[1]), .dbg_cx(cx_w[1]), .dbg_state(st_w[1]),
    .peek_addr(peek), .peek_data(pk_w[1])
  );

  int n_run = 0, n_fail = 0;
  int cyc = 0;
  int halt_at [2];

  always @(posedge clk) cyc <= rst ? 0 : cyc + 1;

  function automatic int pa(int k); return k ? A1 : A0; endfunction
  function automatic int pb(int k); return k ? B1 : B0; endfunction
  function automatic int pn(int k); return k ? N1 : N0; endfunction
  function automatic int sum_of(int k);
    return pa(k) + pn(k) * pb(k) + pn(k) * (pn(k) - 1) / 2;
  endfunction

  task automatic chk(string req, int k, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s dut%0d: actual %0d expected %0d", req, k, act, exp);
    end
  endtask

  task automatic at_cycle(int t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic apply_reset();
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  // R1: reset state
  task automatic t_reset();
    apply_reset();
    for (int k = 0; k < 2; k++) begin
      chk("R1 pc", k, pc_w[k], 0);
      chk("R1 ac", k, ac_w[k], 0);
      chk("R1 state", k, st_w[k], 0);
      chk("R1 halted", k, halt_w[k], 0);
    end
    rst = 1'b0;
  endtask

  // R2..R6: cycle-accurate trace of the first loop pass
  task automatic t_trace();
    at_cycle(1);
    for (int k = 0; k < 2; k++) begin
      chk("R2 pc after first edge", k, pc_w[k], 1);
      chk("R2 state after first edge", k, st_w[k], 1);
    end
    at_cycle(4);
    chk("R2 decode to operand read", 0, st_w[0], 4);
    at_cycle(6);
    for (int k = 0; k < 2; k++) chk("R3 ac loaded", k, ac_w[k], pa(k));
    at_cycle(17);
    for (int k = 0; k < 2; k++) begin
      chk("R4 count loaded", k, cx_w[k], pn(k));
      chk("R4 step immediate", k, bx_w[k], pb(k));
    end
    at_cycle(22);
    for (int k = 0; k < 2; k++) chk("R5 first add", k, ac_w[k], pa(k) + pb(k));
    at_cycle(27);
    for (int k = 0; k < 2; k++) chk("R4 step inc", k, bx_w[k], pb(k) + 1);
    at_cycle(32);
    for (int k = 0; k < 2; k++) chk("R4 count dec", k, cx_w[k], pn(k) - 1);
    at_cycle(37);
    chk("R6 taken jump target", 0, pc_w[0], 3);
    chk("R6 not taken falls through", 1, pc_w[1], 8);
  endtask

  // R7, R8: run to halt and check results
  task automatic t_finish();
    halt_at[0] = -1; halt_at[1] = -1;
    while ((halt_at[0] < 0 || halt_at[1] < 0) && cyc < 3000) begin
      for (int k = 0; k < 2; k++) if (halt_at[k] < 0 && halt_w[k]) halt_at[k] = cyc;
      @(negedge clk);
    end
    for (int k = 0; k < 2; k++) begin
      if (halt_at[k] < 0) chk("R7 reached halt", k, 0, 1);
      chk("R8 halt cycle", k, halt_at[k], 22 + 20 * pn(k));
      chk("R8 acc sum", k, ac_w[k], sum_of(k));
      chk("R8 result word", k, pk_w[k], sum_of(k));
      chk("R8 step final", k, bx_w[k], pb(k) + pn(k));
      chk("R8 count final", k, cx_w[k], 0);
      chk("R8 pc final", k, pc_w[k], 8);
      chk("R7 halt code", k, st_w[k], 13);
    end
  endtask

  // R7: halted machine holds
  task automatic t_hold();
    repeat (20) @(negedge clk);
    for (int k = 0; k < 2; k++) begin
      chk("R7 hold halted", k, halt_w[k], 1);
      chk("R7 hold acc", k, ac_w[k], sum_of(k));
      chk("R7 hold pc", k, pc_w[k], 8);
      chk("R7 hold result word", k, pk_w[k], sum_of(k));
    end
  endtask

  // R1: reset refills memory; a second run matches the first
  task automatic t_rerun();
    apply_reset();
    chk("R1 result word cleared", 0, pk_w[0], 0);
    chk("R1 halted dropped", 0, halt_w[0], 0);
    rst = 1'b0;
    at_cycle(6);
    chk("R1 reloaded start value", 0, ac_w[0], A0);
    at_cycle(22 + 20 * N0);
    chk("R1 rerun halted", 0, halt_w[0], 1);
    chk("R1 rerun result", 0, pk_w[0], 55);
  endtask

  initial begin
    #2_000_000;
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_trace();
    t_finish();
    t_hold();
    t_rerun();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule